// File: doc/BRIEF.md
# Command Slot Control Register File

This block sits behind a serial frame receiver and acts on the two command slots of each received frame. The first slot carries a 20-bit command address word: a read/write flag and a register index. The second slot carries a 20-bit command data word, and the 16-bit write value sits in its upper bits. The receiver presents both words, with their valid tags, together with a single-cycle frame strobe once per frame. The block applies writes to a file of 64 16-bit control registers and prepares read responses.

Register locations are addressed by a 7-bit byte index. Only even indexes name real registers. Index `2*k` selects register `k`, and an odd index names nothing. A read latches the echoed index and the selected data as a response for the transmitter to place in the next outgoing status frame. Every register value is also driven out directly, so the rest of the design can use it.

Top module: `cmdreg_top`

## Requirements
- R1: After reset every register reads 0 on `regOut` and `rspValid` is 0.
- R2: On a frame strobe where both valid tags are set, `slot1Word[19]` is 0 (0 means write) and the index `slot1Word[18:12]` is even, register `index/2` takes the value `slot2Word[19:4]`. The new value is visible on `regOut[(index/2)*16 +: 16]` in the cycle after the strobe.
- R3: A write command whose frame lacks either valid tag changes no register.
- R4: A write command to an odd index changes no register.
- R5: On a frame strobe where `slot1Valid` is set and `slot1Word[19]` is 1 (1 means read), `rspValid` rises in the next cycle. In that cycle `rspIndex` carries the index and `rspData` carries the register contents as they stood before the strobe. All three hold until the next frame strobe. The `slot2Valid` tag plays no part in a read.
- R6: A read of an odd index returns `rspData` equal to 0, with the odd index echoed.
- R7: Reserved bits `slot1Word[11:0]` and `slot2Word[3:0]` have no effect on any register or response.
- R8: While `frameStrobe` is low, the slot words and tags have no effect on any register or response output.
- R9: A frame strobe that carries no valid read command clears `rspValid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frameStrobe | input | 1 | One-cycle pulse when a frame's slots are presented |
| slot1Valid | input | 1 | Valid tag of the command address slot |
| slot2Valid | input | 1 | Valid tag of the command data slot |
| slot1Word | input | 20 | Command address slot, MSB first |
| slot2Word | input | 20 | Command data slot, MSB first |
| rspValid | output | 1 | Read response pending for the next status frame |
| rspIndex | output | 7 | Echoed register index of the read |
| rspData | output | 16 | Read data, 0 for an odd index |
| regOut | output | 1024 | All registers, register k at bits k*16 +: 16 |

## Verification
The bench aims at odd indexes on both paths. A design that decoded the index without looking at its low bit would overwrite the even neighbour on an odd write, or return the neighbour's value on an odd read. Frames with one valid tag missing, and writes with the reserved bits set to ones, show whether the tags are gated and the data field is taken from the correct slice; a wrong slice shifts every stored value. A read followed by a strobe with no read, along with garbage on the slot words between strobes, catches a response that never clears or a decoder that acts without a strobe. A read issued straight after a write to the same register checks that the response carries the value from before the strobe and not a value updated in the same cycle.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
  // Slot and register geometry
  parameter int SLOT_W = 20;
  parameter int IDX_W  = 7;
  parameter int DATA_W = 16;

  localparam int NUM_REGS  = 2 ** (IDX_W - 1);
  localparam int REG_SEL_W = IDX_W - 1;
  localparam int FLAT_W    = NUM_REGS * DATA_W;

  // Field positions inside the command address and command data slots
  localparam int RW_BIT     = SLOT_W - 1;
  localparam int IDX_HI     = SLOT_W - 2;
  localparam int IDX_LO     = SLOT_W - 1 - IDX_W;
  localparam int WDATA_HI   = SLOT_W - 1;
  localparam int WDATA_LO   = SLOT_W - DATA_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic                 rdZero;
    logic                 rspClear;
    logic [REG_SEL_W-1:0] regSel;
    logic [IDX_W-1:0]     idx;
    logic [DATA_W-1:0]    wrData;
  } cmd_strobe_t;
endpackage

// File: rtl/cmdreg_ctrl.sv
module cmdreg_ctrl
  import cmdreg_pkg::*;
(
  input  logic              frameStrobe,
  input  logic              slot1Valid,
  input  logic              slot2Valid,
  input  logic [SLOT_W-1:0] slot1Word,
  input  logic [SLOT_W-1:0] slot2Word,
  output cmd_strobe_t       strobes
);
  logic             isRead;
  logic             isOdd;
  logic             readCmd;
  logic             writeCmd;
  logic [IDX_W-1:0] idxField;

  always_comb begin
    idxField = slot1Word[IDX_HI:IDX_LO];
    isRead   = slot1Word[RW_BIT];
    isOdd    = idxField[0];
    readCmd  = frameStrobe && slot1Valid && isRead;
    writeCmd = frameStrobe && slot1Valid && slot2Valid && !isRead;
  end

  always_comb begin
    strobes          = '0;
    strobes.idx      = idxField;
    strobes.regSel   = idxField[IDX_W-1:1];
    strobes.wrData   = slot2Word[WDATA_HI:WDATA_LO];
    strobes.wrEn     = writeCmd && !isOdd;
    strobes.rdEn     = readCmd;
    strobes.rdZero   = readCmd && isOdd;
    strobes.rspClear = frameStrobe && !readCmd;
  end
endmodule

// File: rtl/cmdreg_datapath.sv
module cmdreg_datapath
  import cmdreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_strobe_t       strobes,
  output logic              rspValid,
  output logic [IDX_W-1:0]  rspIndex,
  output logic [DATA_W-1:0] rspData,
  output logic [FLAT_W-1:0] regOut
);
  logic [DATA_W-1:0]   regArr [NUM_REGS];
  logic [NUM_REGS-1:0] wrSel;
  logic [DATA_W-1:0]   rdMux;

  always_comb begin
    wrSel = '0;
    if (strobes.wrEn) wrSel[strobes.regSel] = 1'b1;
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)        regArr[k] <= '0;
      else if (wrSel[k]) regArr[k] <= strobes.wrData;
    end
    assign regOut[k*DATA_W +: DATA_W] = regArr[k];
  end

  always_comb begin
    rdMux = regArr[strobes.regSel];
    if (strobes.rdZero) rdMux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspIndex <= '0;
      rspData  <= '0;
    end else if (strobes.rdEn) begin
      rspValid <= 1'b1;
      rspIndex <= strobes.idx;
      rspData  <= rdMux;
    end else if (strobes.rspClear) begin
      rspValid <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdreg_top.sv
module cmdreg_top
  import cmdreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameStrobe,
  input  logic              slot1Valid,
  input  logic              slot2Valid,
  input  logic [SLOT_W-1:0] slot1Word,
  input  logic [SLOT_W-1:0] slot2Word,
  output logic              rspValid,
  output logic [IDX_W-1:0]  rspIndex,
  output logic [DATA_W-1:0] rspData,
  output logic [FLAT_W-1:0] regOut
);
  cmd_strobe_t strobes;

  cmdreg_ctrl u_ctrl (
    .frameStrobe(frameStrobe),
    .slot1Valid (slot1Valid),
    .slot2Valid (slot2Valid),
    .slot1Word  (slot1Word),
    .slot2Word  (slot2Word),
    .strobes    (strobes)
  );

  cmdreg_datapath u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .rspValid(rspValid),
    .rspIndex(rspIndex),
    .rspData (rspData),
    .regOut  (regOut)
  );
endmodule

// File: rtl/cmdreg_chk.sv
module cmdreg_chk
  import cmdreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frameStrobe,
  input logic              slot1Valid,
  input logic              slot2Valid,
  input logic [SLOT_W-1:0] slot1Word,
  input logic [SLOT_W-1:0] slot2Word,
  input logic              rspValid,
  input logic [IDX_W-1:0]  rspIndex,
  input logic [DATA_W-1:0] rspData,
  input logic [FLAT_W-1:0] regOut
);
  logic [DATA_W-1:0] obsReg [NUM_REGS];
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_unpack
    assign obsReg[k] = regOut[k*DATA_W +: DATA_W];
  end

  logic readReq, writeEven, writeDropped;
  assign readReq      = frameStrobe && slot1Valid && slot1Word[RW_BIT];
  assign writeEven    = frameStrobe && slot1Valid && slot2Valid && !slot1Word[RW_BIT]
                        && !slot1Word[IDX_LO];
  assign writeDropped = frameStrobe && !slot1Word[RW_BIT]
                        && (!slot1Valid || !slot2Valid || slot1Word[IDX_LO]);

  // R2
  write_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writeEven |=> obsReg[$past(slot1Word[IDX_HI:IDX_LO+1])] == $past(slot2Word[WDATA_HI:WDATA_LO]));

  // R3
  write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writeDropped |=> $stable(regOut));

  // R5
  read_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readReq |=> rspValid && rspIndex == $past(slot1Word[IDX_HI:IDX_LO]));

  // R6
  odd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && rspIndex[0] |-> rspData == '0);

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStrobe |=> $stable(regOut) && $stable(rspValid) && $stable(rspIndex) && $stable(rspData));

  // R9
  rsp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameStrobe && !readReq |=> !rspValid);
endmodule

bind cmdreg_top cmdreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frameStrobe(frameStrobe),
  .slot1Valid(slot1Valid), .slot2Valid(slot2Valid),
  .slot1Word(slot1Word), .slot2Word(slot2Word),
  .rspValid(rspValid), .rspIndex(rspIndex), .rspData(rspData), .regOut(regOut)
);

// File: tb/tb_cmdreg_top.sv
module tb_cmdreg_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frameStrobe = 1'b0;
  logic          slot1Valid = 1'b0;
  logic          slot2Valid = 1'b0;
  logic [19:0]   slot1Word = '0;
  logic [19:0]   slot2Word = '0;
  logic          rspValid;
  logic [6:0]    rspIndex;
  logic [15:0]   rspData;
  logic [1023:0] regOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  int model [64];
  bit expValid;
  int expIndex;
  int expData;

  cmdreg_top dut (
    .clk(clk), .rst_n(rst_n), .frameStrobe(frameStrobe),
    .slot1Valid(slot1Valid), .slot2Valid(slot2Valid),
    .slot1Word(slot1Word), .slot2Word(slot2Word),
    .rspValid(rspValid), .rspIndex(rspIndex), .rspData(rspData), .regOut(regOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic [19:0] mkAddr(bit rd, int idx, bit [11:0] rsv);
    return {rd, 7'(idx), rsv};
  endfunction

  task automatic compareAll(string tag);
    bit regsOk = 1;
    int badK = 0;
    for (int k = 0; k < 64; k++) begin
      if (regOut[k*16 +: 16] !== 16'(model[k]) && regsOk) begin
        regsOk = 0;
        badK = k;
      end
    end
    checks++;
    if (!regsOk) begin
      failures++;
      $display("FAIL %s: reg %0d actual=%h expected=%h", tag, badK,
               regOut[badK*16 +: 16], 16'(model[badK]));
    end
    checks++;
    if (rspValid !== expValid ||
        (expValid && (rspIndex !== 7'(expIndex) || rspData !== 16'(expData)))) begin
      failures++;
      $display("FAIL %s: rsp actual=%b/%h/%h expected=%b/%h/%h", tag,
               rspValid, rspIndex, rspData, expValid, 7'(expIndex), 16'(expData));
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge, compare at the next falling edge
  task automatic step(bit stb, bit v1, bit v2, logic [19:0] w1, logic [19:0] w2, string tag);
    int idx;
    frameStrobe = stb; slot1Valid = v1; slot2Valid = v2; slot1Word = w1; slot2Word = w2;
    @(posedge clk);
    idx = int'(w1[18:12]);
    if (stb) begin
      if (v1 && w1[19]) begin
        expValid = 1;
        expIndex = idx;
        expData  = idx[0] ? 0 : model[idx >> 1];
      end else begin
        expValid = 0;
      end
      if (v1 && v2 && !w1[19] && !idx[0]) model[idx >> 1] = int'(w2[19:4]);
    end
    @(negedge clk);
    frameStrobe = 0;
    compareAll(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++)
      step(0, 1'($urandom), 1'($urandom), 20'($urandom), 20'($urandom), tag);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) model[k] = 0;
    expValid = 0; expIndex = 0; expData = 0;
    repeat (3) @(negedge clk);
    compareAll("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compareAll("R1 after release");

    // R2: write every even register
    for (int k = 0; k < 64; k++)
      step(1, 1, 1, mkAddr(0, 2*k, 0), {16'(16'hA000 + k*37), 4'h0}, "R2 write even");

    // R5: read every even register back
    for (int k = 0; k < 64; k++)
      step(1, 1, 0, mkAddr(1, 2*k, 0), 20'h0, "R5 read even");
    idle(3, "R5 hold");

    // R9: strobe without read clears response
    step(1, 1, 1, mkAddr(1, 10, 0), 20'h0, "R5 read before clear");
    step(1, 0, 0, mkAddr(1, 10, 0), 20'h0, "R9 no valid tag");
    step(1, 1, 0, mkAddr(1, 12, 0), 20'h0, "R5 read");
    step(1, 1, 1, mkAddr(0, 3, 0), 20'hFFFF0, "R9 write strobe clears");

    // R4: odd writes discarded
    for (int k = 0; k < 64; k++)
      step(1, 1, 1, mkAddr(0, 2*k+1, 0), 20'h5A5A0, "R4 odd write");

    // R6: odd reads return zero
    for (int k = 0; k < 64; k += 7)
      step(1, 1, 1, mkAddr(1, 2*k+1, 0), 20'h0, "R6 odd read");

    // R3: missing tags
    step(1, 0, 1, mkAddr(0, 20, 0), 20'h12340, "R3 slot1 tag missing");
    step(1, 1, 0, mkAddr(0, 20, 0), 20'h56780, "R3 slot2 tag missing");
    step(1, 0, 0, mkAddr(0, 20, 0), 20'h9ABC0, "R3 both tags missing");
    step(1, 1, 0, mkAddr(1, 20, 0), 20'h0, "R3 read after dropped writes");

    // R7: reserved bits set
    step(1, 1, 1, mkAddr(0, 30, 12'hFFF), 20'hBEEFF, "R7 reserved bits write");
    step(1, 1, 1, mkAddr(1, 30, 12'hFFF), 20'hFFFFF, "R7 reserved bits read");

    // R5: read right after write to same register returns new value
    step(1, 1, 1, mkAddr(0, 40, 0), 20'h13570, "R2 write then read");
    step(1, 1, 0, mkAddr(1, 40, 0), 20'h0, "R5 read after write");

    // R8: no strobe, garbage inputs
    idle(40, "R8 idle garbage");

    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit stb = ($urandom % 3) != 0;
      step(stb, ($urandom % 5) != 0, ($urandom % 5) != 0, 20'($urandom), 20'($urandom), "R2 R5 mixed");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule